// File: doc/BRIEF.md
# Delimited Byte-Stuffing Frame Writer

This block takes a stream of payload bytes, grouped into packets by an end-of-packet flag, and turns it into a delimited byte stream for a transmit FIFO. Each frame is wrapped between two 0x02 delimiter bytes. Any payload byte that could be mistaken for framing, 0x02 or 0x10, is sent after a 0x10 escape byte. A receiver can therefore recover packet boundaries from the raw byte stream.

The block writes into the downstream FIFO in bursts of one byte per cycle. It starts a burst only when the FIFO reports that it is completely empty. Each burst is capped, so that an escaped byte and the closing delimiter still fit in the FIFO once the payload budget is spent. A packet longer than one burst continues in later bursts, and the frame stays open in between. A frame-open flag ensures that the opening delimiter is written only once per frame. A status output reports how many payload bytes the most recent burst consumed. A synchronous abort input drops a half-sent frame without closing it.

Top module: `frame_stuffer`

## Requirements
- R1: A frame's first output byte is the delimiter 0x02. It is written only when no frame is open, and writing it raises `frame_open_o`.
- R2: Every payload byte equal to 0x02 or 0x10 is output immediately after an escape byte 0x10. All other payload bytes are output unchanged and in order.
- R3: In the cycle after the byte flagged by `in_last_i` is accepted, a closing 0x02 is output. From the following cycle, `frame_open_o` is low.
- R4: A burst starts only in a cycle when `fifo_empty_i` is high and a payload byte is offered. The bytes of one burst are output in consecutive cycles.
- R5: Within a burst, a payload byte is accepted only while fewer than FIFO_DEPTH-RESERVE bytes (62 by default) have been output in that burst, counting delimiters and escapes. A burst never outputs more than FIFO_DEPTH (64) bytes.
- R6: When a burst ends before the end of the packet, `frame_open_o` stays high. The next burst continues the payload without a new opening delimiter.
- R7: At most one byte is output per cycle. `in_ready_o` is low in every cycle in which an escape byte or a delimiter is output, and every accepted byte is output in the same cycle.
- R8: After a burst ends, `burst_taken_o` holds the number of payload bytes accepted during that burst, until the next burst ends.
- R9: In a cycle with `abort_i` high, the block outputs nothing and accepts nothing. From the next cycle `frame_open_o` is low, and no closing delimiter has been output, so the next packet begins with a fresh opening delimiter.
- R10: After reset, `out_valid_o`, `in_ready_o`, `frame_open_o` and `burst_taken_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abort_i | input | 1 | Drop the open frame without a closing delimiter |
| in_data_i | input | 8 | Payload byte |
| in_valid_i | input | 1 | Payload byte offered |
| in_last_i | input | 1 | Offered byte ends its packet |
| in_ready_o | output | 1 | Payload byte accepted this cycle |
| out_data_o | output | 8 | Byte written to the downstream FIFO |
| out_valid_o | output | 1 | Write strobe for the downstream FIFO |
| fifo_empty_i | input | 1 | Downstream FIFO holds no bytes |
| frame_open_o | output | 1 | An opening delimiter has been written and its frame is not yet closed |
| burst_taken_o | output | CNT_W (7) | Payload bytes consumed by the most recent burst |

## Verification
The checks take for granted that the payload source behaves like a standard valid/ready source. Once `in_valid_i` is raised, it and `in_data_i`/`in_last_i` stay put until the byte is accepted. This matters most while an escape byte is on the output, because the byte it escapes is taken in the following cycle. The checks also assume that `fifo_empty_i` comes from a FIFO that only the block fills, so it cannot read empty while the block's own writes are still pending. The stimulus keeps to these rules. It inserts idle gaps only before raising valid. It models the downstream FIFO as an occupancy counter, filled by the write strobe and drained at a programmable rate, and drives `fifo_empty_i` from that counter.

// File: rtl/fstuff_pkg.sv
package fstuff_pkg;

    localparam int          FS_BYTE_W = 8;
    localparam logic [7:0]  FS_DELIM  = 8'h02;
    localparam logic [7:0]  FS_ESCAPE = 8'h10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_BODY,
        ST_ESCD,
        ST_CLOSE
    } fs_state_e;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_DELIM,
        SEL_ESC,
        SEL_DATA
    } fs_sel_e;

    typedef struct packed {
        logic start;
        logic finish;
        logic emit;
        logic take;
    } fs_ctl_t;

    function automatic logic fs_needs_escape(input logic [FS_BYTE_W-1:0] b);
        return (b == FS_DELIM) || (b == FS_ESCAPE);
    endfunction

endpackage

// File: rtl/fs_burst_meter.sv
module fs_burst_meter
    import fstuff_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int RESERVE    = 2,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1),
    localparam int LIMIT     = FIFO_DEPTH - RESERVE
) (
    input  logic             clk,
    input  logic             rst,
    input  fs_ctl_t          ctl_i,
    output logic             room_o,
    output logic [CNT_W-1:0] taken_o
);

    logic [CNT_W-1:0] emitted_q;
    logic [CNT_W-1:0] taken_q;
    logic [CNT_W-1:0] last_q;

    assign room_o  = (emitted_q < CNT_W'(LIMIT));
    assign taken_o = last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            emitted_q <= '0;
            taken_q   <= '0;
            last_q    <= '0;
        end else begin
            if (ctl_i.start) begin
                emitted_q <= '0;
                taken_q   <= '0;
            end else begin
                if (ctl_i.emit) emitted_q <= emitted_q + CNT_W'(1);
                if (ctl_i.take) taken_q   <= taken_q + CNT_W'(1);
            end
            if (ctl_i.finish) last_q <= taken_q + (ctl_i.take ? CNT_W'(1) : CNT_W'(0));
        end
    end

endmodule

// File: rtl/fs_byte_mux.sv
module fs_byte_mux
    import fstuff_pkg::*;
(
    input  fs_sel_e              sel_i,
    input  logic [FS_BYTE_W-1:0] data_i,
    output logic [FS_BYTE_W-1:0] byte_o
);

    always_comb begin
        unique case (sel_i)
            SEL_DELIM: byte_o = FS_DELIM;
            SEL_ESC:   byte_o = FS_ESCAPE;
            SEL_DATA:  byte_o = data_i;
            default:   byte_o = '0;
        endcase
    end

endmodule

// File: rtl/fs_frame_fsm.sv
module fs_frame_fsm
    import fstuff_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    abort_i,
    input  logic    in_valid_i,
    input  logic    in_last_i,
    input  logic    needs_esc_i,
    input  logic    fifo_empty_i,
    input  logic    room_i,
    output fs_ctl_t ctl_o,
    output fs_sel_e sel_o,
    output logic    frame_open_o
);

    fs_state_e st_q, st_d;
    logic      open_q;
    logic      open_set, open_clr;

    always_comb begin
        st_d     = st_q;
        ctl_o    = '0;
        sel_o    = SEL_NONE;
        open_set = 1'b0;
        open_clr = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (fifo_empty_i && in_valid_i) begin
                    ctl_o.start = 1'b1;
                    st_d        = open_q ? ST_BODY : ST_OPEN;
                end
            end
            ST_OPEN: begin
                sel_o      = SEL_DELIM;
                ctl_o.emit = 1'b1;
                open_set   = 1'b1;
                st_d       = ST_BODY;
            end
            ST_BODY: begin
                if (in_valid_i && room_i) begin
                    ctl_o.emit = 1'b1;
                    if (needs_esc_i) begin
                        sel_o = SEL_ESC;
                        st_d  = ST_ESCD;
                    end else begin
                        sel_o      = SEL_DATA;
                        ctl_o.take = 1'b1;
                        st_d       = in_last_i ? ST_CLOSE : ST_BODY;
                    end
                end else begin
                    ctl_o.finish = 1'b1;
                    st_d         = ST_IDLE;
                end
            end
            ST_ESCD: begin
                if (in_valid_i) begin
                    sel_o      = SEL_DATA;
                    ctl_o.emit = 1'b1;
                    ctl_o.take = 1'b1;
                    st_d       = in_last_i ? ST_CLOSE : ST_BODY;
                end
            end
            ST_CLOSE: begin
                sel_o        = SEL_DELIM;
                ctl_o.emit   = 1'b1;
                ctl_o.finish = 1'b1;
                open_clr     = 1'b1;
                st_d         = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
        if (abort_i) begin
            ctl_o        = '0;
            ctl_o.finish = (st_q != ST_IDLE);
            sel_o        = SEL_NONE;
            open_set     = 1'b0;
            open_clr     = 1'b1;
            st_d         = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            open_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (open_clr)      open_q <= 1'b0;
            else if (open_set) open_q <= 1'b1;
        end
    end

    assign frame_open_o = open_q;

endmodule

// File: rtl/frame_stuffer.sv
module frame_stuffer
    import fstuff_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int RESERVE    = 2,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             abort_i,
    input  logic [7:0]       in_data_i,
    input  logic             in_valid_i,
    input  logic             in_last_i,
    output logic             in_ready_o,
    output logic [7:0]       out_data_o,
    output logic             out_valid_o,
    input  logic             fifo_empty_i,
    output logic             frame_open_o,
    output logic [CNT_W-1:0] burst_taken_o
);

    fs_ctl_t ctl;
    fs_sel_e sel;
    logic    room;
    logic    needs_esc;

    assign needs_esc = fs_needs_escape(in_data_i);

    fs_frame_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .abort_i      (abort_i),
        .in_valid_i   (in_valid_i),
        .in_last_i    (in_last_i),
        .needs_esc_i  (needs_esc),
        .fifo_empty_i (fifo_empty_i),
        .room_i       (room),
        .ctl_o        (ctl),
        .sel_o        (sel),
        .frame_open_o (frame_open_o)
    );

    fs_burst_meter #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .RESERVE    (RESERVE)
    ) u_meter (
        .clk     (clk),
        .rst     (rst),
        .ctl_i   (ctl),
        .room_o  (room),
        .taken_o (burst_taken_o)
    );

    fs_byte_mux u_mux (
        .sel_i  (sel),
        .data_i (in_data_i),
        .byte_o (out_data_o)
    );

    assign in_ready_o  = ctl.take;
    assign out_valid_o = ctl.emit;

endmodule

// File: rtl/fs_checker.sv
module fs_checker
    import fstuff_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    localparam int RUN_W     = $clog2(FIFO_DEPTH + 2) + 1
) (
    input logic       clk,
    input logic       rst,
    input logic       abort_i,
    input logic [7:0] in_data_i,
    input logic       in_valid_i,
    input logic       in_ready_o,
    input logic [7:0] out_data_o,
    input logic       out_valid_o,
    input logic       fifo_empty_i,
    input logic       frame_open_o
);

    logic [RUN_W-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || !out_valid_o) run_len <= '0;
        else if (run_len != {RUN_W{1'b1}}) run_len <= run_len + RUN_W'(1);
    end

    // R2
    esc_before_special_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && in_ready_o && fs_needs_escape(in_data_i))
            |-> ($past(out_valid_o) && ($past(out_data_o) == FS_ESCAPE)));

    // R3
    close_or_abort_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(frame_open_o)
            |-> ($past(abort_i) || ($past(out_valid_o) && ($past(out_data_o) == FS_DELIM))));

    // R4
    burst_on_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid_o) |-> $past(fifo_empty_i));

    // R5
    burst_len_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |-> (run_len < RUN_W'(FIFO_DEPTH)));

    // R7
    accept_emits_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && in_ready_o) |-> out_valid_o);

    // R9
    abort_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        abort_i |-> (!out_valid_o && !in_ready_o));

    // R9
    abort_closes_chk: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> !frame_open_o);

endmodule

bind frame_stuffer fs_checker #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .abort_i      (abort_i),
    .in_data_i    (in_data_i),
    .in_valid_i   (in_valid_i),
    .in_ready_o   (in_ready_o),
    .out_data_o   (out_data_o),
    .out_valid_o  (out_valid_o),
    .fifo_empty_i (fifo_empty_i),
    .frame_open_o (frame_open_o)
);

// File: tb/sim_frame_stuffer.sv
`timescale 1ns/1ps
module sim_frame_stuffer;

    localparam int DEPTH = 64;
    localparam int LIM   = 62;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       abort_i = 1'b0;
    logic [7:0] in_data_i = 8'h00;
    logic       in_valid_i = 1'b0;
    logic       in_last_i = 1'b0;
    logic       in_ready_o;
    logic [7:0] out_data_o;
    logic       out_valid_o;
    logic       fifo_empty_i = 1'b1;
    logic       frame_open_o;
    logic [6:0] burst_taken_o;

    always #4 clk = ~clk;

    frame_stuffer u0 (
        .clk           (clk),
        .rst           (rst),
        .abort_i       (abort_i),
        .in_data_i     (in_data_i),
        .in_valid_i    (in_valid_i),
        .in_last_i     (in_last_i),
        .in_ready_o    (in_ready_o),
        .out_data_o    (out_data_o),
        .out_valid_o   (out_valid_o),
        .fifo_empty_i  (fifo_empty_i),
        .frame_open_o  (frame_open_o),
        .burst_taken_o (burst_taken_o)
    );

    int compared = 0;
    int mismatched = 0;

    logic [7:0] drv_q[$];
    bit         drv_last[$];
    logic [7:0] exp_q[$];

    bit abort_req = 0;
    bit gappy = 0;
    int drain_period = 1;
    bit running = 0;

    int occ = 0;
    int occ_next = 0;
    bit pop_pending = 0;
    bit prev_out = 0;
    bit prev_last_hs = 0;
    bit prev2_last_hs = 0;
    bit have_run = 0;
    int run_len = 0;
    int run_take = 0;
    int runs = 0;
    int cyc = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic bit special(input logic [7:0] b);
        return (b == 8'h02) || (b == 8'h10);
    endfunction

    task automatic add_bytes(input logic [7:0] p[$], input bit open_new, input bit close);
        if (open_new) exp_q.push_back(8'h02);
        foreach (p[i]) begin
            if (special(p[i])) exp_q.push_back(8'h10);
            exp_q.push_back(p[i]);
            drv_q.push_back(p[i]);
            drv_last.push_back(close && (i == p.size() - 1));
        end
        if (close) exp_q.push_back(8'h02);
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 6) begin
            @(posedge clk);
            if (drv_q.size() == 0 && exp_q.size() == 0 && !out_valid_o && !in_valid_i) quiet++;
            else quiet = 0;
        end
    endtask

    // Driver, FIFO model and per-cycle comparison
    always @(negedge clk) begin
        if (running) begin
            cyc++;
            if (pop_pending) begin
                void'(drv_q.pop_front());
                void'(drv_last.pop_front());
            end
            occ = occ_next;
            fifo_empty_i = (occ == 0);
            abort_i = abort_req;
            if (!in_valid_i || pop_pending)
                in_valid_i = (drv_q.size() > 0) && (!gappy || ($urandom_range(3) != 0));
            if (in_valid_i) begin
                in_data_i = drv_q[0];
                in_last_i = drv_last[0];
            end else begin
                in_last_i = 1'b0;
            end
            #1;
            begin
                bit hs;
                bit drain;
                hs = in_valid_i && in_ready_o;
                pop_pending = hs;
                // R7: accepted byte is output in the same cycle
                if (hs) check(out_valid_o, "R7 accept-output", out_valid_o, 1);
                // R7: escape or delimiter cycles do not accept
                if (out_valid_o && !hs)
                    check(out_data_o == 8'h02 || out_data_o == 8'h10, "R7 inserted byte", out_data_o, 8'h10);
                // R3: closing delimiter right after last byte
                if (prev_last_hs)
                    check(out_valid_o && out_data_o == 8'h02, "R3 closing delimiter", out_data_o, 8'h02);
                if (prev2_last_hs)
                    check(!frame_open_o, "R3 frame flag clear", frame_open_o, 0);
                // R9: nothing during abort
                if (abort_i) check(!out_valid_o && !in_ready_o, "R9 quiet abort", out_valid_o, 0);
                if (out_valid_o && !prev_out) begin
                    // R4: burst starts with an empty FIFO
                    check(occ == 0, "R4 start on empty", occ, 0);
                    // R8: status reflects previous burst
                    if (have_run) check(burst_taken_o == run_take, "R8 burst count", burst_taken_o, run_take);
                    // R1: opening delimiter when no frame open
                    if (!frame_open_o) check(out_data_o == 8'h02, "R1 opening delimiter", out_data_o, 8'h02);
                    have_run = 1;
                    run_len = 0;
                    run_take = 0;
                    runs++;
                end
                if (out_valid_o) begin
                    run_len++;
                    // R5
                    check(run_len <= DEPTH, "R5 burst length", run_len, DEPTH);
                    // R2: stream content with escapes
                    if (exp_q.size() == 0) check(0, "R2 stream extra byte", out_data_o, 0);
                    else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        check(out_data_o == e, "R2 stream byte", out_data_o, e);
                    end
                end
                if (hs) begin
                    run_take++;
                    // R5: payload budget per burst
                    check(run_take <= LIM, "R5 payload budget", run_take, LIM);
                end
                prev2_last_hs = prev_last_hs;
                prev_last_hs = hs && in_last_i;
                prev_out = out_valid_o;
                drain = (occ > 0) && ((cyc % drain_period) == 0);
                occ_next = occ + (out_valid_o ? 1 : 0) - (drain ? 1 : 0);
                // R5: downstream FIFO never overflows
                if (out_valid_o) check(occ_next <= DEPTH, "R5 fifo overflow", occ_next, DEPTH);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [7:0] p[$];
        int runs0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #2;
        // R10
        check(!out_valid_o, "R10 out_valid", out_valid_o, 0);
        check(!in_ready_o, "R10 in_ready", in_ready_o, 0);
        check(!frame_open_o, "R10 frame_open", frame_open_o, 0);
        check(burst_taken_o == 0, "R10 burst_taken", burst_taken_o, 0);
        @(posedge clk);
        rst = 1'b0;
        running = 1;

        // plain packet
        p = '{8'h41, 8'h42, 8'h43};
        add_bytes(p, 1, 1);
        wait_idle();

        // escapes (R2)
        p = '{8'h02, 8'h10, 8'h55, 8'h10, 8'h02};
        add_bytes(p, 1, 1);
        wait_idle();
        check(burst_taken_o == 5, "R8 count after escapes", burst_taken_o, 5);

        // single special byte packets, back to back
        p = '{8'h02};
        add_bytes(p, 1, 1);
        p = '{8'h10};
        add_bytes(p, 1, 1);
        wait_idle();

        // long packet over several bursts (R6), slow drain with gaps
        drain_period = 3;
        gappy = 1;
        p = {};
        for (int i = 0; i < 150; i++) p.push_back(8'((i * 7) % 37));
        runs0 = runs;
        add_bytes(p, 1, 1);
        wait_idle();
        check(runs - runs0 >= 3, "R6 multi-burst frame", runs - runs0, 3);

        // all escapes, budget edge (R5)
        gappy = 0;
        drain_period = 2;
        p = {};
        for (int i = 0; i < 100; i++) p.push_back(8'h10);
        add_bytes(p, 1, 1);
        wait_idle();

        // partial frame then abort (R6, R9)
        drain_period = 1;
        p = '{8'h11, 8'h02, 8'h22};
        add_bytes(p, 1, 0);
        wait_idle();
        @(negedge clk);
        #2;
        check(frame_open_o, "R6 frame stays open", frame_open_o, 1);
        check(burst_taken_o == 3, "R8 partial count", burst_taken_o, 3);
        @(posedge clk);
        abort_req = 1;
        @(posedge clk);
        abort_req = 0;
        @(negedge clk);
        #2;
        check(!frame_open_o, "R9 abort clears frame", frame_open_o, 0);
        check(!out_valid_o, "R9 no closing delimiter", out_valid_o, 0);
        p = '{8'h33, 8'h34};
        add_bytes(p, 1, 1);
        wait_idle();
        @(negedge clk);
        #2;
        check(burst_taken_o == run_take, "R8 final count", burst_taken_o, run_take);
        check(exp_q.size() == 0, "R2 stream drained", exp_q.size(), 0);

        running = 0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule